// File: doc/BRIEF.md
# Keyed Configuration Port Register File

This block implements the register side of an index/data configuration interface for an I/O controller that holds four UARTs. A byte-wide bus with one address bit reaches two ports: the index port at offset 0 and the data port at offset 1. The host unlocks the interface by writing a key byte to the index port twice in a row. It then selects a register through the index port and reads or writes that register through the data port. Writing 0xAA to the index port locks the interface again.

A logical-device register selects which of the four per-device banks the data port reaches. Each bank holds an I/O base address, an interrupt-mode byte and an RS-485 control byte. The interrupt-mode and RS-485 bytes of every device drive output ports, which go to the UART and interrupt logic. Fixed identification registers let software find the part. Bus address decode, the UARTs and interrupt routing lie outside this block.

Top module: `cfg_port_regfile`

## Requirements
- R1: After reset the interface is locked. The logical device is 0, every interrupt-mode and RS-485 byte is 0x00, and a data-port read returns 0xFF.
- R2: The interface unlocks only when the index port receives two consecutive writes of the key chosen by `key_sel_i`. The encoding is 0 = 0x77, 1 = 0xA0, 2 = 0x87 and 3 = 0x67. A different key written twice leaves the interface locked.
- R3: Any other index-port write made while locked clears a pending first key byte. The sequence key, other, key therefore does not unlock.
- R4: While unlocked, writing 0xAA to the index port locks the interface.
- R5: While locked, index-port and data-port writes are ignored, and a read from either port returns 0xFF.
- R6: Index 0x23 reads 0x19 and index 0x24 reads 0x34.
- R7: Index 0x20 reads the low byte and index 0x21 the high byte of the chip code. The code is 0x1602, or 0x0501 when `chip_alt_i` is 1.
- R8: Index 0x07 holds the logical device number in bits 1:0, and the upper bits read as 0. This number selects the bank that indices 0x60, 0x61, 0x70 and 0xF0 reach.
- R9: Index 0x60 is the high byte and index 0x61 the low byte of a device's I/O base, and both are writable. The reset bases are 0x3F8, 0x2F8, 0x3E8 and 0x2E8 for devices 0 to 3.
- R10: Index 0x70 is a full-byte read/write interrupt-mode register for each device. In it, bit 4 means shared and bits 6:5 give the mode (00 = level active-low, 01 = edge active-high). Device n drives `irq_cfg_o[8n+7:8n]`.
- R11: Index 0xF0 is a full-byte read/write RS-485 register for each device. In it, bit 5 inverts RTS, bit 4 selects automatic direction, bit 3 enables a receive four-character wait and bit 2 enables a transmit four-character wait. Device n drives `rs485_cfg_o[8n+7:8n]`.
- R12: Writes to the identification registers and to unimplemented indices have no effect, and unimplemented indices read 0x00.
- R13: While unlocked, an index-port read returns the selected index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 = index port, 1 = data port |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_i is 1, otherwise 0 |
| key_sel_i | input | 2 | Entry key strap |
| chip_alt_i | input | 1 | Chip code strap |
| unlocked_o | output | 1 | Configuration mode active |
| irq_cfg_o | output | 32 | Interrupt-mode byte for each device |
| rs485_cfg_o | output | 32 | RS-485 control byte for each device |

## Verification
Directed key sequences exercise the unlock logic. These are the right key twice, a wrong key twice, and the right key broken by another byte. Together they separate a correct detector from one that counts key bytes that are not adjacent, or one that accepts any key. Random writes and readbacks spread over random logical devices and a mix of bank, global, identification and unused indices. These catch a bank select that writes the wrong device, identification registers that accept writes, and unused indices that keep data. Writes made while locked, followed by an unlock and a readback, show whether locking really blocks access.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] EXIT_KEY   = 8'hAA;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_CHIP_L = 8'h20;
  localparam logic [7:0] IDX_CHIP_H = 8'h21;
  localparam logic [7:0] IDX_VEND_A = 8'h23;
  localparam logic [7:0] IDX_VEND_B = 8'h24;
  localparam logic [7:0] IDX_BASE_H = 8'h60;
  localparam logic [7:0] IDX_BASE_L = 8'h61;
  localparam logic [7:0] IDX_IRQ    = 8'h70;
  localparam logic [7:0] IDX_RS485  = 8'hF0;
  localparam logic [7:0] VEND_A_VAL = 8'h19;
  localparam logic [7:0] VEND_B_VAL = 8'h34;
  localparam logic [15:0] CHIP_MAIN = 16'h1602;
  localparam logic [15:0] CHIP_ALT  = 16'h0501;

  function automatic logic [7:0] key_value(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'h77;
      2'd1:    return 8'hA0;
      2'd2:    return 8'h87;
      default: return 8'h67;
    endcase
  endfunction

  function automatic logic [15:0] dev_reset_base(input int unsigned n);
    case (n)
      0:       return 16'h03F8;
      1:       return 16'h02F8;
      2:       return 16'h03E8;
      3:       return 16'h02E8;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic is_bank_idx(input logic [7:0] idx);
    return (idx == IDX_BASE_H) || (idx == IDX_BASE_L) ||
           (idx == IDX_IRQ) || (idx == IDX_RS485);
  endfunction
endpackage

// File: rtl/cfg_key_unlock.sv
module cfg_key_unlock
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_we_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] key_i,
  output logic       unlocked_o
);
  logic first_q;
  logic unl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b0;
      unl_q   <= 1'b0;
    end else if (idx_we_i) begin
      if (unl_q) begin
        first_q <= 1'b0;
        if (wdata_i == EXIT_KEY) unl_q <= 1'b0;
      end else if (wdata_i == key_i) begin
        // second adjacent key byte opens the port
        unl_q   <= first_q;
        first_q <= ~first_q;
      end else begin
        first_q <= 1'b0;
      end
    end
  end

  assign unlocked_o = unl_q;
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] RST_BASE = 16'h03F8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [7:0] irq_o,
  output logic [7:0] rs485_o
);
  logic [15:0] base_q;
  logic [7:0]  irq_q;
  logic [7:0]  rs485_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= RST_BASE;
      irq_q   <= 8'h00;
      rs485_q <= 8'h00;
    end else if (we_i) begin
      case (idx_i)
        IDX_BASE_H: base_q[15:8] <= wdata_i;
        IDX_BASE_L: base_q[7:0]  <= wdata_i;
        IDX_IRQ:    irq_q        <= wdata_i;
        IDX_RS485:  rs485_q      <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx_i)
      IDX_BASE_H: rdata_o = base_q[15:8];
      IDX_BASE_L: rdata_o = base_q[7:0];
      IDX_IRQ:    rdata_o = irq_q;
      IDX_RS485:  rdata_o = rs485_q;
      default:    rdata_o = 8'h00;
    endcase
  end

  assign irq_o   = irq_q;
  assign rs485_o = rs485_q;
endmodule

// File: rtl/cfg_port_regfile.sv
module cfg_port_regfile
  import cfg_port_pkg::*;
#(
  parameter int unsigned NUM_DEV = 4,
  localparam int unsigned LDN_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 addr_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  input  logic [1:0]           key_sel_i,
  input  logic                 chip_alt_i,
  output logic                 unlocked_o,
  output logic [NUM_DEV*8-1:0] irq_cfg_o,
  output logic [NUM_DEV*8-1:0] rs485_cfg_o
);
  logic             unlocked;
  logic             idx_we, dat_we;
  logic [7:0]       idx_q;
  logic [LDN_W-1:0] ldn_q;
  logic [7:0]       bank_rd [NUM_DEV];
  logic [7:0]       data_rd;
  logic [15:0]      chip_code;

  assign idx_we = wr_i & ~addr_i;
  assign dat_we = wr_i & addr_i & unlocked;

  cfg_key_unlock u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_we_i   (idx_we),
    .wdata_i    (wdata_i),
    .key_i      (key_value(key_sel_i)),
    .unlocked_o (unlocked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= 8'h00;
      ldn_q <= '0;
    end else begin
      if (idx_we && unlocked && wdata_i != EXIT_KEY) idx_q <= wdata_i;
      if (dat_we && idx_q == IDX_LDN) ldn_q <= wdata_i[LDN_W-1:0];
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    cfg_dev_bank #(.RST_BASE(dev_reset_base(d))) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (dat_we && ldn_q == LDN_W'(d)),
      .idx_i   (idx_q),
      .wdata_i (wdata_i),
      .rdata_o (bank_rd[d]),
      .irq_o   (irq_cfg_o[d*8 +: 8]),
      .rs485_o (rs485_cfg_o[d*8 +: 8])
    );
  end

  assign chip_code = chip_alt_i ? CHIP_ALT : CHIP_MAIN;

  always_comb begin
    if (is_bank_idx(idx_q)) data_rd = bank_rd[ldn_q];
    else begin
      case (idx_q)
        IDX_LDN:    data_rd = 8'(ldn_q);
        IDX_CHIP_L: data_rd = chip_code[7:0];
        IDX_CHIP_H: data_rd = chip_code[15:8];
        IDX_VEND_A: data_rd = VEND_A_VAL;
        IDX_VEND_B: data_rd = VEND_B_VAL;
        default:    data_rd = 8'h00;
      endcase
    end
  end

  always_comb begin
    if (!rd_i)          rdata_o = 8'h00;
    else if (!unlocked) rdata_o = 8'hFF;
    else if (addr_i)    rdata_o = data_rd;
    else                rdata_o = idx_q;
  end

  assign unlocked_o = unlocked;
endmodule

// File: rtl/cfg_port_regfile_chk.sv
module cfg_port_regfile_chk
  import cfg_port_pkg::*;
#(
  parameter int unsigned NUM_DEV = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 addr_i,
  input logic                 wr_i,
  input logic                 rd_i,
  input logic [7:0]           wdata_i,
  input logic [7:0]           rdata_o,
  input logic [1:0]           key_sel_i,
  input logic                 chip_alt_i,
  input logic                 unlocked_o,
  input logic [NUM_DEV*8-1:0] irq_cfg_o,
  input logic [NUM_DEV*8-1:0] rs485_cfg_o,
  input logic [7:0]           idx_q
);
  a_r5_locked_read_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && rd_i) |-> rdata_o == 8'hFF);

  a_r4_exit_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && wr_i && !addr_i && wdata_i == EXIT_KEY) |=> !unlocked_o);

  a_r2_unlock_on_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(wr_i && !addr_i && wdata_i == key_value(key_sel_i)));

  a_r5_locked_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && $past(!unlocked_o)) |-> ($stable(irq_cfg_o) && $stable(rs485_cfg_o)));

  a_r6_vendor_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && rd_i && addr_i && idx_q == IDX_VEND_A) |-> rdata_o == VEND_A_VAL);

  a_r7_chip_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && rd_i && addr_i && idx_q == IDX_CHIP_L) |->
      rdata_o == (chip_alt_i ? 8'h01 : 8'h02));
endmodule

bind cfg_port_regfile cfg_port_regfile_chk #(.NUM_DEV(NUM_DEV)) u_chk (.*);

// File: tb/cfg_port_regfile_tb_top.sv
module cfg_port_regfile_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  wdata_i = 8'h00;
  logic [7:0]  rdata_o;
  logic [1:0]  key_sel_i = 2'd0;
  logic        chip_alt_i = 1'b0;
  logic        unlocked_o;
  logic [31:0] irq_cfg_o, rs485_cfg_o;

  int checks = 0, fails = 0;
  logic [15:0] m_base [4];
  logic [7:0]  m_irq [4], m_rs [4];
  logic [1:0]  m_ldn;

  always #5 clk_i = ~clk_i;

  cfg_port_regfile dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [7:0] d);
    wr(1'b0, idx); rd(1'b1, d);
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] idx);
    case (idx)
      8'h07: return {6'b0, m_ldn};
      8'h20: return chip_alt_i ? 8'h01 : 8'h02;
      8'h21: return chip_alt_i ? 8'h05 : 8'h16;
      8'h23: return 8'h19;
      8'h24: return 8'h34;
      8'h60: return m_base[m_ldn][15:8];
      8'h61: return m_base[m_ldn][7:0];
      8'h70: return m_irq[m_ldn];
      8'hF0: return m_rs[m_ldn];
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] idx, input logic [7:0] d);
    case (idx)
      8'h07: m_ldn = d[1:0];
      8'h60: m_base[m_ldn][15:8] = d;
      8'h61: m_base[m_ldn][7:0] = d;
      8'h70: m_irq[m_ldn] = d;
      8'hF0: m_rs[m_ldn] = d;
      default: ;
    endcase
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] idx_pool [10] = '{8'h07, 8'h20, 8'h21, 8'h23, 8'h24,
                                  8'h60, 8'h61, 8'h70, 8'hF0, 8'h3C};
    void'($urandom(32'd1234));
    m_base = '{16'h03F8, 16'h02F8, 16'h03E8, 16'h02E8};
    m_irq = '{default: 8'h00}; m_rs = '{default: 8'h00}; m_ldn = 2'd0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 unlocked", unlocked_o, 0);
    chk("R1 irq_cfg", irq_cfg_o, 0);
    chk("R1 rs485_cfg", rs485_cfg_o, 0);
    rd(1'b1, d); chk("R1 data read", d, 8'hFF);
    // R5 locked: index read 0xFF
    rd(1'b0, d); chk("R5 locked index read", d, 8'hFF);
    // R3 broken key sequence
    wr(0, 8'h77); wr(0, 8'h11); wr(0, 8'h77);
    chk("R3 broken sequence", unlocked_o, 0);
    wr(0, 8'h11);
    // R2 wrong key twice
    wr(0, 8'hA0); wr(0, 8'hA0);
    chk("R2 wrong key", unlocked_o, 0);
    wr(0, 8'h77); wr(0, 8'h77);
    chk("R2 right key", unlocked_o, 1);
    // R13 index readback
    wr(0, 8'h23); rd(0, d); chk("R13 index read", d, 8'h23);
    // R6 vendor
    rd(1, d); chk("R6 vendor 0x23", d, 8'h19);
    rd_reg(8'h24, d); chk("R6 vendor 0x24", d, 8'h34);
    // R7 chip id both straps
    rd_reg(8'h20, d); chk("R7 chip lo", d, 8'h02);
    rd_reg(8'h21, d); chk("R7 chip hi", d, 8'h16);
    chip_alt_i = 1'b1;
    rd_reg(8'h20, d); chk("R7 alt chip lo", d, 8'h01);
    rd_reg(8'h21, d); chk("R7 alt chip hi", d, 8'h05);
    chip_alt_i = 1'b0;
    // R12 read-only id and unused index
    wr(0, 8'h20); wr(1, 8'hFF); rd(1, d); chk("R12 id write ignored", d, 8'h02);
    wr(0, 8'h55); wr(1, 8'hAB); rd(1, d); chk("R12 unused index", d, 8'h00);
    // R9 reset bases
    for (int n = 0; n < 4; n++) begin
      wr(0, 8'h07); wr(1, 8'(n)); m_ldn = 2'(n);
      rd_reg(8'h60, d); chk("R9 base hi", d, m_base[n][15:8]);
      rd_reg(8'h61, d); chk("R9 base lo", d, m_base[n][7:0]);
    end
    // R8 ldn upper bits read 0
    wr(0, 8'h07); wr(1, 8'hFD); m_ldn = 2'd1;
    rd(1, d); chk("R8 ldn read", d, 8'h01);
    // R8 R10 R11 R9 R12 random traffic
    for (int i = 0; i < 300; i++) begin
      logic [7:0] idx, val;
      idx = idx_pool[$urandom_range(0, 9)];
      val = 8'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        wr(0, 8'h07); wr(1, val); model_wr(8'h07, val);
      end
      wr(0, idx); wr(1, val); model_wr(idx, val);
      rd(1, d); chk("R10 R11 R8 random readback", d, exp_rd(idx));
      chk("R10 irq outputs", irq_cfg_o, {m_irq[3], m_irq[2], m_irq[1], m_irq[0]});
      chk("R11 rs485 outputs", rs485_cfg_o, {m_rs[3], m_rs[2], m_rs[1], m_rs[0]});
    end
    // R4 exit, R5 locked writes ignored
    wr(0, 8'h70); wr(0, 8'hAA);
    chk("R4 exit locks", unlocked_o, 0);
    rd(1, d); chk("R5 locked data read", d, 8'hFF);
    wr(1, ~m_irq[m_ldn]); wr(0, 8'hF0);
    chk("R5 locked irq outputs", irq_cfg_o, {m_irq[3], m_irq[2], m_irq[1], m_irq[0]});
    wr(0, 8'h77); wr(0, 8'h77);
    rd(0, d); chk("R5 locked index write ignored", d, 8'h70);
    rd(1, d); chk("R5 locked data write ignored", d, m_irq[m_ldn]);
    wr(0, 8'hAA);
    // R2 alternate key strap
    key_sel_i = 2'd3;
    wr(0, 8'h77); wr(0, 8'h77); chk("R2 old key rejected", unlocked_o, 0);
    wr(0, 8'h67); wr(0, 8'h67); chk("R2 key sel 3", unlocked_o, 1);
    wr(0, 8'hAA);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule